// File: doc/BRIEF.md
# Even-Ratio Programmable Clock Generator

This block derives a bus clock from one of two free-running root clocks. A single configuration word, written through a plain write port in the configuration clock domain, picks the root clock, sets an even division ratio, turns the generator on or off, routes the generator onto the bus-clock output, and optionally adds a divide-by-two stage after the generator. Changing the root clock goes through a glitch-free clock multiplexer. This lets software move the bus clock between roots while the bus clock is running.

The ratio field holds a value N, and the generator divides the selected root clock by 2*(N+1). The output is high for N+1 root cycles and low for N+1 root cycles. For example, a 384 MHz root with N = 2, 3 and 5 gives 64, 48 and 32 MHz. A 396 MHz root with N = 2 and 5 gives 66 and 33 MHz. Each write to the configuration word restarts the divide counter, so the new ratio is loaded before the next output edge.

Top module: `even_clk_gen`

## Requirements
- R1: During reset and after it, the bus clock is low. The configuration word resets to all zero, so the generator is disabled and produces no edges until a write enables it.
- R2: Let N be the value in field bits [7:0]. The bus clock period is 2*(N+1) periods of the selected root. With N = 0 the root is divided by two. With N = 2 it is divided by six.
- R3: The bus clock is high for exactly half of its period, which is N+1 root periods.
- R4: While the enable bit (bit 9) is 0, the bus clock stays low. This holds even if the post-divide bit is set.
- R5: The source bit (bit 8) selects the root clock. A value of 0 selects the auxiliary root. A value of 1 selects the processor root.
- R6: While the route bit (bit 10) is 0, no generator drives the bus clock and the bus clock stays low. When the route bit is 1, the generator drives the bus clock.
- R7: When the post-divide bit (bit 11) is 1, the routed clock is divided by a further two, and the duty cycle stays at 50%. When the bit is 0, the generator output passes through unchanged.
- R8: When the source is switched while the clock runs, no bus clock pulse is shorter than half a period of the faster root. At most one root-clock enable is active at any time.
- R9: A configuration write restarts the divide counter. After the write, the new ratio holds without any pulse shorter than half a root period.
- R10: A cycle with the write strobe low does not change the configuration. Any value on the data port in such a cycle has no effect.
- R11: The divide counter never exceeds the ratio value that the generator has latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgClk | input | 1 | Configuration write clock |
| cfgRstN | input | 1 | Asynchronous active-low reset for all domains |
| auxClk | input | 1 | Auxiliary root clock (source 0) |
| cpuClk | input | 1 | Processor root clock (source 1) |
| cfgWrEn | input | 1 | Write strobe for the configuration word |
| cfgWrData | input | 12 | Configuration word: [7:0] ratio N, [8] source, [9] enable, [10] route, [11] post-divide |
| busClk | output | 1 | Routed bus clock output |

## Verification
A single write can change the root source and the ratio together. The clock multiplexer handover and the divide-counter restart then occur in the same stretch of output cycles. The bench provokes this with one write that flips the source bit and loads a new N. It also switches the source back and forth while the divider runs at its fastest ratio. Throughout these windows the bench watches every bus-clock edge for the shortest pulse. It then judges the result by that minimum width against half the faster root period, and by the period and high time measured afterwards against the new ratio on the new root.

// File: rtl/even_clk_gen_pkg.sv
`timescale 1ps/1ps
package even_clk_gen_pkg;
  localparam int DIV_W     = 8;
  localparam int NUM_SRC   = 2;
  localparam int SRC_BIT   = DIV_W;
  localparam int EN_BIT    = DIV_W + 1;
  localparam int ROUTE_BIT = DIV_W + 2;
  localparam int POST_BIT  = DIV_W + 3;
  localparam int CFG_W     = DIV_W + 4;
  localparam int SYNC_LEN  = 2;

  typedef struct packed {
    logic [DIV_W-1:0] divVal;
    logic             srcSel;
    logic             genEn;
    logic             routeEn;
    logic             postDiv;
    logic             divWrTgl;
  } cgCtrl_t;
endpackage

// File: rtl/even_clk_gen_ctrl.sv
`timescale 1ps/1ps
module even_clk_gen_ctrl
  import even_clk_gen_pkg::*;
(
  input  logic             cfgClk,
  input  logic             cfgRstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output cgCtrl_t          ctrl
);

  always_ff @(posedge cfgClk or negedge cfgRstN) begin
    if (!cfgRstN) begin
      ctrl <= '0;
    end else if (cfgWrEn) begin
      ctrl.divVal   <= cfgWrData[DIV_W-1:0];
      ctrl.srcSel   <= cfgWrData[SRC_BIT];
      ctrl.genEn    <= cfgWrData[EN_BIT];
      ctrl.routeEn  <= cfgWrData[ROUTE_BIT];
      ctrl.postDiv  <= cfgWrData[POST_BIT];
      ctrl.divWrTgl <= ~ctrl.divWrTgl;
    end
  end

  // R9: each write flips the restart toggle seen by the divider domain
  assert_wr_toggle_R9: assert property (@(posedge cfgClk) disable iff (!cfgRstN)
    cfgWrEn |=> (ctrl.divWrTgl != $past(ctrl.divWrTgl)));

  // R10: no strobe, no change
  assert_idle_hold_R10: assert property (@(posedge cfgClk) disable iff (!cfgRstN)
    !cfgWrEn |=> $stable(ctrl));

endmodule

// File: rtl/even_clk_gen_dp.sv
`timescale 1ps/1ps
module even_clk_gen_dp
  import even_clk_gen_pkg::*;
(
  input  logic    rstN,
  input  logic    auxClk,
  input  logic    cpuClk,
  input  cgCtrl_t ctrl,
  output logic    busClk
);

  logic [NUM_SRC-1:0] rootClk;
  logic [NUM_SRC-1:0] branchEn;
  logic               muxClk;

  assign rootClk = {cpuClk, auxClk};

  // Glitch-free root multiplexer: one handshake branch per root clock
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_branch
    logic reqEn;
    logic stageP;
    logic stageN;

    always_comb begin
      reqEn = (ctrl.srcSel == 1'(i)) &&
              !(|(branchEn & ~(NUM_SRC'(1) << i)));
    end

    always_ff @(posedge rootClk[i] or negedge rstN) begin
      if (!rstN) stageP <= 1'b0;
      else       stageP <= reqEn;
    end

    // enable changes only while this root is low
    always_ff @(negedge rootClk[i] or negedge rstN) begin
      if (!rstN) stageN <= 1'b0;
      else       stageN <= stageP;
    end

    assign branchEn[i] = stageN;
  end

  assign muxClk = |(rootClk & branchEn);

  // Divider domain
  logic [SYNC_LEN:0]   tglSync;
  logic [SYNC_LEN-1:0] enSync;
  logic                restart;
  logic                enLive;
  logic [DIV_W-1:0]    cnt;
  logic [DIV_W-1:0]    divLatch;
  logic                genOut;
  logic                postQ;
  logic                postRstN;

  always_ff @(posedge muxClk or negedge rstN) begin
    if (!rstN) begin
      tglSync <= '0;
      enSync  <= '0;
    end else begin
      tglSync <= {tglSync[SYNC_LEN-1:0], ctrl.divWrTgl};
      enSync  <= {enSync[SYNC_LEN-2:0], ctrl.genEn};
    end
  end

  assign restart = tglSync[SYNC_LEN] ^ tglSync[SYNC_LEN-1];
  assign enLive  = enSync[SYNC_LEN-1];

  always_ff @(posedge muxClk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      divLatch <= '0;
      genOut   <= 1'b0;
    end else if (restart) begin
      cnt      <= '0;
      divLatch <= ctrl.divVal;
      genOut   <= 1'b0;
    end else if (!enLive) begin
      cnt    <= '0;
      genOut <= 1'b0;
    end else if (cnt == divLatch) begin
      cnt    <= '0;
      genOut <= ~genOut;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  // Optional divide-by-two after the generator, cleared while disabled
  assign postRstN = rstN & enLive;

  always_ff @(posedge genOut or negedge postRstN) begin
    if (!postRstN) postQ <= 1'b0;
    else           postQ <= ~postQ;
  end

  assign busClk = ctrl.routeEn & (ctrl.postDiv ? postQ : genOut);

  // R11: counter bounded by the latched ratio
  assert_cnt_bound_R11: assert property (@(posedge muxClk) disable iff (!rstN)
    cnt <= divLatch);

  // R2: output flips once the count reaches the ratio
  assert_toggle_at_limit_R2: assert property (@(posedge muxClk) disable iff (!rstN)
    (enLive && !restart && cnt == divLatch) |=> (genOut != $past(genOut)));

  // R4: disabled generator stays low
  assert_hold_low_R4: assert property (@(posedge muxClk) disable iff (!rstN)
    (!enLive && !restart) |=> !genOut);

  // R8: never two roots enabled together
  assert_mux_excl_aux_R8: assert property (@(posedge auxClk) disable iff (!rstN)
    $onehot0(branchEn));
  assert_mux_excl_cpu_R8: assert property (@(posedge cpuClk) disable iff (!rstN)
    $onehot0(branchEn));

endmodule

// File: rtl/even_clk_gen.sv
`timescale 1ps/1ps
module even_clk_gen
  import even_clk_gen_pkg::*;
(
  input  logic             cfgClk,
  input  logic             cfgRstN,
  input  logic             auxClk,
  input  logic             cpuClk,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic             busClk
);

  cgCtrl_t ctrl;

  even_clk_gen_ctrl u_ctrl (
    .cfgClk    (cfgClk),
    .cfgRstN   (cfgRstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .ctrl      (ctrl)
  );

  even_clk_gen_dp u_dp (
    .rstN   (cfgRstN),
    .auxClk (auxClk),
    .cpuClk (cpuClk),
    .ctrl   (ctrl),
    .busClk (busClk)
  );

endmodule

// File: tb/even_clk_gen_tb.sv
`timescale 1ps/1ps
module even_clk_gen_tb;

  localparam int CLK_HALF = 2500;                 // 200 MHz
  localparam int AUX_MUL  = 32;                   // 384 MHz root
  localparam int CPU_MUL  = 33;                   // 396 MHz root
  localparam int AUX_HALF = 1000000 / (24 * AUX_MUL);
  localparam int CPU_HALF = 1000000 / (24 * CPU_MUL);
  localparam int TA = 2 * AUX_HALF;
  localparam int TC = 2 * CPU_HALF;
  localparam int MIN_HALF = (AUX_HALF < CPU_HALF) ? AUX_HALF : CPU_HALF;

  logic cfgClk = 1'b0, auxClk = 1'b0, cpuClk = 1'b0;
  logic cfgRstN = 1'b0, cfgWrEn = 1'b0;
  logic [11:0] cfgWrData = '0;
  logic busClk;

  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_HALF) cfgClk = ~cfgClk;
  always #(AUX_HALF) auxClk = ~auxClk;
  always #(CPU_HALF) cpuClk = ~cpuClk;

  even_clk_gen u_dut (
    .cfgClk(cfgClk), .cfgRstN(cfgRstN), .auxClk(auxClk), .cpuClk(cpuClk),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .busClk(busClk)
  );

  // Edge monitor: behavioural measurement of the output waveform
  int     riseCnt = 0;
  longint lastRise = 0, periodLast = 0, highLast = 0;
  longint lastEdge = 0, monStart = 0, minW = 0;
  bit     monOn = 0;

  always @(posedge busClk) begin
    periodLast = $time - lastRise;
    lastRise   = $time;
    riseCnt++;
  end
  always @(negedge busClk) highLast = $time - lastRise;
  always @(busClk) begin
    if (monOn && lastEdge >= monStart && ($time - lastEdge) < minW)
      minW = $time - lastEdge;
    lastEdge = $time;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge cfgClk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] cfgWord(input int n, input bit src, input bit en,
                                          input bit route, input bit post);
    return {post, route, en, src, 8'(n)};
  endfunction

  task automatic writeCfg(input logic [11:0] w);
    @(negedge cfgClk);
    cfgWrData = w; cfgWrEn = 1'b1;
    @(negedge cfgClk);
    cfgWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge cfgClk);
  endtask

  task automatic waitRises(input int n, input string req);
    int target = riseCnt + n;
    int t = 0;
    while (riseCnt < target && t < 3000) begin
      @(negedge cfgClk);
      t++;
    end
    check(riseCnt >= target, req, riseCnt, target);
  endtask

  // Reference: period = 2*(N+1)*Troot, doubled by post-divide; high = half
  task automatic measure(input int n, input bit src, input bit post, input string req);
    longint expP = longint'(2 * (n + 1)) * (src ? TC : TA) * (post ? 2 : 1);
    waitRises(6, req);
    check(periodLast >= expP - 1 && periodLast <= expP + 1, {req, " period"}, periodLast, expP);
    check(highLast >= expP / 2 - 1 && highLast <= expP / 2 + 1, "R3 high time", highLast, expP / 2);
  endtask

  task automatic expectQuiet(input string req);
    int r0;
    idle(20);
    r0 = riseCnt;
    idle(100);
    check(riseCnt == r0, req, riseCnt - r0, 0);
    check(busClk == 1'b0, req, busClk, 0);
  endtask

  initial begin
    // R1: reset state
    idle(5);
    check(busClk == 1'b0, "R1 in reset", busClk, 0);
    idle(5);
    cfgRstN = 1'b1;
    expectQuiet("R1 after reset");

    // R2/R3/R5: ratios on the auxiliary root (source 0)
    writeCfg(cfgWord(2, 0, 1, 1, 0)); measure(2, 0, 0, "R2 div6 aux");
    writeCfg(cfgWord(3, 0, 1, 1, 0)); measure(3, 0, 0, "R2 div8 aux");
    writeCfg(cfgWord(5, 0, 1, 1, 0)); measure(5, 0, 0, "R2 div12 aux");
    writeCfg(cfgWord(0, 0, 1, 1, 0)); measure(0, 0, 0, "R2 div2 aux");

    // R5: processor root (source 1)
    writeCfg(cfgWord(2, 1, 1, 1, 0)); measure(2, 1, 0, "R5 div6 cpu");
    writeCfg(cfgWord(5, 1, 1, 1, 0)); measure(5, 1, 0, "R5 div12 cpu");

    // R7: post-divide set, then cleared again
    writeCfg(cfgWord(2, 1, 1, 1, 1)); measure(2, 1, 1, "R7 post on");

    // R10: data without strobe has no effect
    @(negedge cfgClk);
    cfgWrData = cfgWord(7, 0, 0, 0, 0);
    idle(30);
    measure(2, 1, 1, "R10 no strobe");
    writeCfg(cfgWord(2, 1, 1, 1, 0)); measure(2, 1, 0, "R7 post off");

    // R6: route cleared
    writeCfg(cfgWord(2, 1, 1, 0, 0)); expectQuiet("R6 route off");
    // R4: enable cleared, with and without post-divide
    writeCfg(cfgWord(2, 1, 0, 1, 0)); expectQuiet("R4 disabled");
    writeCfg(cfgWord(1, 0, 1, 1, 1)); measure(1, 0, 1, "R7 post aux");
    writeCfg(cfgWord(1, 0, 0, 1, 1)); expectQuiet("R4 disabled post");

    // R8: source switching at the fastest ratio
    writeCfg(cfgWord(0, 0, 1, 1, 0)); waitRises(6, "R8 start");
    minW = 64'd1 << 40; monStart = $time; monOn = 1;
    writeCfg(cfgWord(0, 1, 1, 1, 0)); idle(30);
    writeCfg(cfgWord(0, 0, 1, 1, 0)); idle(30);
    writeCfg(cfgWord(0, 1, 1, 1, 0));
    measure(0, 1, 0, "R5 after switch");
    monOn = 0;
    check(minW >= MIN_HALF, "R8 min pulse switch", minW, MIN_HALF);

    // R8/R9: source and ratio change in the same write
    minW = 64'd1 << 40; monStart = $time; monOn = 1;
    writeCfg(cfgWord(3, 0, 1, 1, 0));
    measure(3, 0, 0, "R9 combined");
    monOn = 0;
    check(minW >= MIN_HALF, "R8 min pulse combined", minW, MIN_HALF);

    // R9: ratio rewrite while running
    minW = 64'd1 << 40; monStart = $time; monOn = 1;
    writeCfg(cfgWord(4, 0, 1, 1, 0));
    measure(4, 0, 0, "R9 rewrite");
    monOn = 0;
    check(minW >= MIN_HALF, "R9 min pulse rewrite", minW, MIN_HALF);

    summary();
    $finish;
  end

endmodule